// File: doc/BRIEF.md
# Four-Slot Pulse-Position Modulator

The block turns a stream of 2-bit symbols into a 4-PPM line signal. Time is cut into frames; each frame opens with four pulse slots of one clock each, and when a symbol was taken for the frame exactly one of those slots carries a high level. The slot number equals the symbol value. A free-running slot timer marks the first slot of every frame (the load slot). On that slot the held symbol is loaded into a small down-counter, and the output goes high in the slot where the count reaches zero. The zero test uses the symbol itself in the load slot, and a pulse state machine stops the count from reaching zero a second time in the same frame.

Symbols arrive in one of two ways, chosen by the `SERIAL_IN` parameter. In parallel mode a 2-bit symbol is offered with a valid/ready handshake, and ready is high only in the last slot of each frame. In serial mode single bits are shifted in, most significant bit first, and each completed pair waits in a pending register until the frame boundary takes it. `GAP_SLOTS` appends silent slots after the four pulse slots, so a frame is `4 + GAP_SLOTS` clocks long. The pulse state machine has three states. `FS_EMPTY` means no symbol was taken for the frame. `FS_ARMED` means the counter is still counting down to its pulse slot. `FS_SENT` means the pulse has been emitted. A load slot moves the machine to `FS_EMPTY` when no symbol is held, to `FS_SENT` for symbol 0 (pulse emitted in the load slot), and to `FS_ARMED` for symbols 1 to 3. `FS_ARMED` moves to `FS_SENT` in the slot where the count is zero.

Top module: `ppm4_modulator`

## Requirements
- R1: A frame lasts 4 + GAP_SLOTS clock cycles. The first cycle after reset is the load slot (slot 0) of a frame.
- R2: A symbol with value v (0 to 3) that is accepted on a clock edge produces one high output cycle. That cycle is slot v of the next frame, counted from 0 at the load slot, which is the cycle right after the accepting edge.
- R3: A frame that holds a symbol has exactly one high output cycle. A frame for which no symbol was accepted stays low in every slot.
- R4: In parallel mode, sym_ready is high only in the last slot of each frame. A symbol is taken only on an edge where both sym_valid and sym_ready are high. Data offered in any other cycle has no effect on the output.
- R5: The output is low in every idle slot (slots 4 to 3 + GAP_SLOTS) of every frame.
- R6: In serial mode, a bit is shifted in on an edge where both ser_valid and ser_ready are high. The first bit of a pair is symbol bit 1 and the second is bit 0. The completed pair is pending until the next last-slot edge takes it. ser_ready is low while a pair is pending, and bits offered then are ignored.
- R7: Synchronous reset (rst high) clears the slot timer, the pulse state, the held symbol and any partial or pending serial bits. ppm_out is low while rst is high.
- R8: Only the handshake of the selected mode is ever ready. In parallel mode ser_ready stays low, and in serial mode sym_ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst | input | 1 | Synchronous reset, active high |
| sym_data | input | 2 | Parallel-mode symbol value |
| sym_valid | input | 1 | Parallel-mode symbol offered |
| sym_ready | output | 1 | Parallel-mode symbol taken this cycle if valid |
| ser_bit | input | 1 | Serial-mode data bit |
| ser_valid | input | 1 | Serial-mode bit offered |
| ser_ready | output | 1 | Serial-mode bit taken this cycle if valid |
| ppm_out | output | 1 | Pulse-position modulated line output |

## Verification
The handshake results are combinational from registered state, so sym_ready and ser_ready are compared in the same cycle as the slot they belong to. A symbol accepted on the edge that closes cycle c is due on ppm_out in cycle c + 1 + v. The bench's reference model stores that exact cycle number as soon as it sees the accepting handshake. At every falling edge it compares the output against membership in that set, which also checks every empty frame and every idle slot. For serial input, the model tracks the half-collected pair and the pending pair by itself, so a pair is scheduled only on a frame's last slot, and only when it was complete before that edge.

// File: rtl/ppm4_pkg.sv
`timescale 1ns/1ps
package ppm4_pkg;

    localparam int unsigned PULSE_SLOTS = 4;

    typedef logic [1:0] sym_t;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_ARMED = 2'd1,
        FS_SENT  = 2'd2
    } frame_state_e;

    function automatic int unsigned frame_len(input int unsigned gap);
        return PULSE_SLOTS + gap;
    endfunction

endpackage

// File: rtl/ppm4_slot_timer.sv
`timescale 1ns/1ps
module ppm4_slot_timer #(
    parameter int unsigned FRAME_LEN = 4,
    parameter int unsigned TW        = 2
) (
    input  logic          clk,
    input  logic          rst,
    output logic [TW-1:0] tcnt,
    output logic          load_slot,
    output logic          last_slot
);

    localparam logic [TW-1:0] LAST = TW'(FRAME_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt <= '0;
        end else if (tcnt == LAST) begin
            tcnt <= '0;
        end else begin
            tcnt <= tcnt + 1'b1;
        end
    end

    assign load_slot = (tcnt == '0);
    assign last_slot = (tcnt == LAST);

endmodule

// File: rtl/ppm4_sym_source.sv
`timescale 1ns/1ps
module ppm4_sym_source
    import ppm4_pkg::*;
#(
    parameter bit SERIAL_IN = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic last_slot,
    input  sym_t sym_data,
    input  logic sym_valid,
    output logic sym_ready,
    input  logic ser_bit,
    input  logic ser_valid,
    output logic ser_ready,
    output sym_t hold,
    output logic hold_vld
);

    sym_t src_sym;
    logic src_vld;

    generate
        if (SERIAL_IN) begin : g_serial
            sym_t shreg;
            logic have_msb;
            sym_t pend;
            logic pend_vld;
            logic bit_take;
            logic unused_par;

            assign unused_par = ^{sym_data, sym_valid};
            assign ser_ready  = !pend_vld;
            assign sym_ready  = 1'b0;
            assign bit_take   = ser_valid && ser_ready;

            always_ff @(posedge clk) begin
                if (rst) begin
                    shreg    <= '0;
                    have_msb <= 1'b0;
                    pend     <= '0;
                    pend_vld <= 1'b0;
                end else begin
                    if (last_slot && pend_vld) begin
                        pend_vld <= 1'b0;
                    end
                    if (bit_take) begin
                        shreg <= {shreg[0], ser_bit};
                        if (have_msb) begin
                            pend     <= {shreg[0], ser_bit};
                            pend_vld <= 1'b1;
                            have_msb <= 1'b0;
                        end else begin
                            have_msb <= 1'b1;
                        end
                    end
                end
            end

            assign src_sym = pend;
            assign src_vld = pend_vld;
        end else begin : g_parallel
            logic unused_ser;

            assign unused_ser = ser_bit ^ ser_valid;
            assign sym_ready  = last_slot;
            assign ser_ready  = 1'b0;
            assign src_sym    = sym_data;
            assign src_vld    = sym_valid;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hold     <= '0;
            hold_vld <= 1'b0;
        end else if (last_slot) begin
            hold_vld <= src_vld;
            if (src_vld) begin
                hold <= src_sym;
            end
        end
    end

endmodule

// File: rtl/ppm4_pulse_fsm.sv
`timescale 1ns/1ps
module ppm4_pulse_fsm
    import ppm4_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_slot,
    input  sym_t hold,
    input  logic hold_vld,
    output logic pulse
);

    frame_state_e state_q, state_d;
    sym_t         dcnt_q, dcnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_EMPTY;
            dcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            dcnt_q  <= dcnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        dcnt_d  = dcnt_q;
        if (load_slot) begin
            dcnt_d = hold - 2'd1;
            if (!hold_vld) begin
                state_d = FS_EMPTY;
            end else if (hold == 2'd0) begin
                state_d = FS_SENT;
            end else begin
                state_d = FS_ARMED;
            end
        end else begin
            unique case (state_q)
                FS_ARMED: begin
                    if (dcnt_q == 2'd0) begin
                        state_d = FS_SENT;
                    end else begin
                        dcnt_d = dcnt_q - 2'd1;
                    end
                end
                FS_EMPTY, FS_SENT: begin
                    state_d = state_q;
                end
                default: state_d = FS_EMPTY;
            endcase
        end
    end

    always_comb begin
        pulse = 1'b0;
        if (load_slot) begin
            pulse = hold_vld && (hold == 2'd0);
        end else begin
            unique case (state_q)
                FS_ARMED: pulse = (dcnt_q == 2'd0);
                default:  pulse = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ppm4_modulator.sv
`timescale 1ns/1ps
module ppm4_modulator
    import ppm4_pkg::*;
#(
    parameter int unsigned GAP_SLOTS = 0,
    parameter bit          SERIAL_IN = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sym_data,
    input  logic       sym_valid,
    output logic       sym_ready,
    input  logic       ser_bit,
    input  logic       ser_valid,
    output logic       ser_ready,
    output logic       ppm_out
);

    localparam int unsigned FRAME_LEN = frame_len(GAP_SLOTS);
    localparam int unsigned TW        = $clog2(FRAME_LEN);

    logic [TW-1:0] tcnt;
    logic          load_slot;
    logic          last_slot;
    sym_t          hold;
    logic          hold_vld;
    logic          pulse;

    ppm4_slot_timer #(
        .FRAME_LEN(FRAME_LEN),
        .TW       (TW)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tcnt     (tcnt),
        .load_slot(load_slot),
        .last_slot(last_slot)
    );

    ppm4_sym_source #(
        .SERIAL_IN(SERIAL_IN)
    ) u_source (
        .clk      (clk),
        .rst      (rst),
        .last_slot(last_slot),
        .sym_data (sym_data),
        .sym_valid(sym_valid),
        .sym_ready(sym_ready),
        .ser_bit  (ser_bit),
        .ser_valid(ser_valid),
        .ser_ready(ser_ready),
        .hold     (hold),
        .hold_vld (hold_vld)
    );

    ppm4_pulse_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .load_slot(load_slot),
        .hold     (hold),
        .hold_vld (hold_vld),
        .pulse    (pulse)
    );

    assign ppm_out = pulse && !rst;

endmodule

// File: rtl/ppm4_checker.sv
`timescale 1ns/1ps
module ppm4_checker
    import ppm4_pkg::*;
#(
    parameter int unsigned GAP_SLOTS = 0
) (
    input logic                                   clk,
    input logic                                   rst,
    input logic [$clog2(frame_len(GAP_SLOTS))-1:0] tcnt,
    input logic [1:0]                             sym_data,
    input logic                                   sym_valid,
    input logic                                   sym_ready,
    input logic                                   ser_ready,
    input logic                                   ppm_out
);

    localparam int unsigned FL = frame_len(GAP_SLOTS);
    localparam int unsigned TW = $clog2(FL);

    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
        end else if (tcnt == TW'(FL - 1)) begin
            seen_q <= 1'b0;
        end else if (ppm_out) begin
            seen_q <= 1'b1;
        end
    end

    AST_ONE_PULSE_PER_FRAME: assert property (@(posedge clk) disable iff (rst) seen_q |-> !ppm_out); // R3
    AST_ZERO_SYMBOL_AT_LOAD: assert property (@(posedge clk) disable iff (rst) (sym_ready && sym_valid && sym_data == 2'd0) |=> ppm_out); // R2
    AST_EMPTY_FRAME_LOW: assert property (@(posedge clk) disable iff (rst) (sym_ready && !sym_valid) |=> !ppm_out); // R4
    AST_READY_BEFORE_LOAD: assert property (@(posedge clk) disable iff (rst) sym_ready |=> (tcnt == '0)); // R1
    AST_IDLE_SLOT_QUIET: assert property (@(posedge clk) disable iff (rst) (int'(tcnt) >= 4) |-> !ppm_out); // R5
    AST_SINGLE_MODE_READY: assert property (@(posedge clk) disable iff (rst) $onehot0({sym_ready, ser_ready})); // R8
    AST_RESET_QUIET: assert property (@(posedge clk) rst |-> !ppm_out); // R7

endmodule

bind ppm4_modulator ppm4_checker #(
    .GAP_SLOTS(GAP_SLOTS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tcnt     (tcnt),
    .sym_data (sym_data),
    .sym_valid(sym_valid),
    .sym_ready(sym_ready),
    .ser_ready(ser_ready),
    .ppm_out  (ppm_out)
);

// File: tb/tb_ppm4_modulator.sv
`timescale 1ns/1ps
module tb_ppm4_modulator;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sym_data = '0;
    logic       sym_valid = 1'b0;
    logic       ser_bit = 1'b0;
    logic       ser_valid = 1'b0;

    logic rdy_a, srdy_a, out_a;
    logic rdy_g, srdy_g, out_g;
    logic rdy_s, srdy_s, out_s;

    int nvec  = 0;
    int nfail = 0;
    int cyc   = 0;

    bit exp_a[int];
    bit exp_g[int];
    bit exp_s[int];

    bit       m_has_msb, m_msb, m_pend;
    bit [1:0] m_pend_sym;

    always #10 clk = ~clk;

    ppm4_modulator #(.GAP_SLOTS(0), .SERIAL_IN(1'b0)) dut (
        .clk(clk), .rst(rst), .sym_data(sym_data), .sym_valid(sym_valid), .sym_ready(rdy_a),
        .ser_bit(ser_bit), .ser_valid(ser_valid), .ser_ready(srdy_a), .ppm_out(out_a));

    ppm4_modulator #(.GAP_SLOTS(3), .SERIAL_IN(1'b0)) dut_gap (
        .clk(clk), .rst(rst), .sym_data(sym_data), .sym_valid(sym_valid), .sym_ready(rdy_g),
        .ser_bit(ser_bit), .ser_valid(ser_valid), .ser_ready(srdy_g), .ppm_out(out_g));

    ppm4_modulator #(.GAP_SLOTS(0), .SERIAL_IN(1'b1)) dut_ser (
        .clk(clk), .rst(rst), .sym_data(sym_data), .sym_valid(sym_valid), .sym_ready(rdy_s),
        .ser_bit(ser_bit), .ser_valid(ser_valid), .ser_ready(srdy_s), .ppm_out(out_s));

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    function automatic string pulse_req(input bit expv, input int slot, input int flen);
        if (slot >= 4) return "R5";
        if (expv)      return "R2";
        return "R3/R4";
    endfunction

    task automatic compare_cycle();
        bit ea, eg, es;
        ea = exp_a.exists(cyc);
        eg = exp_g.exists(cyc);
        es = exp_s.exists(cyc);
        chk(out_a == ea, pulse_req(ea, cyc % 4, 4), out_a, ea);
        chk(out_g == eg, pulse_req(eg, cyc % 7, 7), out_g, eg);
        chk(out_s == es, (es ? "R6" : "R3"), out_s, es);
        chk(rdy_a == (cyc % 4 == 3), "R1", rdy_a, (cyc % 4 == 3));
        chk(rdy_g == (cyc % 7 == 6), "R1", rdy_g, (cyc % 7 == 6));
        chk(srdy_s == !m_pend, "R6", srdy_s, !m_pend);
        chk((srdy_a | srdy_g | rdy_s) == 1'b0, "R8", srdy_a | srdy_g | rdy_s, 0);
    endtask

    task automatic model_step();
        bit acc;
        bit new_pend;
        // parallel instances: taken only on their last slot
        if (sym_valid && (cyc % 4 == 3)) exp_a[cyc + 1 + int'(sym_data)] = 1'b1;
        if (sym_valid && (cyc % 7 == 6)) exp_g[cyc + 1 + int'(sym_data)] = 1'b1;
        // serial instance, R6: MSB first, pair pending until a last slot
        acc = m_pend && (cyc % 4 == 3);
        if (acc) exp_s[cyc + 1 + int'(m_pend_sym)] = 1'b1;
        new_pend = m_pend && !acc;
        if (ser_valid && !m_pend) begin
            if (!m_has_msb) begin
                m_msb     = ser_bit;
                m_has_msb = 1'b1;
            end else begin
                m_pend_sym = {m_msb, ser_bit};
                new_pend   = 1'b1;
                m_has_msb  = 1'b0;
            end
        end
        m_pend = new_pend;
    endtask

    task automatic apply_reset(input int cycles);
        rst       = 1'b1;
        sym_valid = 1'b0;
        ser_valid = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk(out_a == 1'b0 && out_g == 1'b0 && out_s == 1'b0, "R7", out_a | out_g | out_s, 0);
        end
        exp_a.delete();
        exp_g.delete();
        exp_s.delete();
        m_has_msb = 1'b0;
        m_pend    = 1'b0;
        m_msb     = 1'b0;
        cyc       = 0;
        rst       = 1'b0;
    endtask

    task automatic run(input int n, input int valid_pct);
        for (int k = 0; k < n; k++) begin
            compare_cycle();
            sym_valid = ($urandom_range(99) < valid_pct);
            sym_data  = 2'($urandom_range(3));
            ser_valid = ($urandom_range(99) < valid_pct);
            ser_bit   = 1'($urandom_range(1));
            model_step();
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        #4000000;
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        @(negedge clk);
        apply_reset(3);
        run(800, 100);   // back-to-back symbols
        run(1200, 50);   // sparse offers, empty frames
        run(300, 0);     // nothing offered, all frames empty
        // reset in mid stream, with a serial pair in progress, R7
        ser_valid = 1'b1;
        ser_bit   = 1'b1;
        @(negedge clk);
        apply_reset(2);
        run(800, 70);
        run(200, 100);
        report();
    end

endmodule